// File: doc/BRIEF.md
# Measurement Limit Alert Unit

This block watches finished conversion results for two monitored sources, the on-chip temperature reading and the auxiliary/battery reading, and compares each one against a programmable lower and upper bound. A result that falls outside its window sets a sticky flag. There is one flag for the low side and one for the high side of each source. The flags stay set until the host clears them through a write-one-to-clear port.

The unit combines the flags into one active-low alert pin, with a mask bit for each source. A mode bit hands the same pin over to general-purpose output use. In that mode the pin follows a data bit from the control word, and the flags keep updating in the background.

The 16-bit control word is split into two bytes. The upper byte carries the alert controls. The lower byte carries the channel-sequence enables, and a result is only checked when its channel is enabled there.

Top module: `lim_alert_top`

## Requirements
- R1: After a synchronous active-low reset, all four flags read 0 and `alert_n` is 1 (with mode bit 0).
- R2: A temperature result (tag 3'd5) strictly below `temp_lo` sets `flags[0]`, and one strictly above `temp_hi` sets `flags[1]`. A value equal to either bound sets neither flag. Flags appear on the clock edge that samples the result.
- R3: An auxiliary result (tag 3'd6) strictly below `aux_lo` sets `flags[2]`, and one strictly above `aux_hi` sets `flags[3]`. A value equal to either bound sets neither flag.
- R4: When `res_valid` is 0, or the tag is neither 3'd5 nor 3'd6, the flags do not change.
- R5: Temperature results are checked only while `ctrl_word[2]` is 1, and auxiliary results only while `ctrl_word[3]` is 1. Otherwise the result is ignored.
- R6: A flag stays set until `clr_we` is 1 with a 1 in the matching bit of `clr_mask`. Writing 0 to a bit leaves that flag unchanged.
- R7: If a flag is being set and cleared in the same cycle, the set wins and the flag ends up 1.
- R8: With `ctrl_word[13]`=0, `alert_n` is 0 exactly when some unmasked flag is set. It follows the flags combinationally.
- R9: `ctrl_word[15]` masks the temperature flags and `ctrl_word[14]` masks the auxiliary flags from the alert. Masked flags still set and still read back.
- R10: With `ctrl_word[13]`=1, `alert_n` equals `ctrl_word[12]`, and the flags continue to update as in R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Result-written strobe |
| res_tag | input | 3 | Channel tag of the result |
| res_data | input | DATA_W | Converted value |
| temp_lo | input | DATA_W | Temperature lower bound |
| temp_hi | input | DATA_W | Temperature upper bound |
| aux_lo | input | DATA_W | Auxiliary lower bound |
| aux_hi | input | DATA_W | Auxiliary upper bound |
| ctrl_word | input | 16 | Upper byte: alert controls. Lower byte: sequence enables |
| clr_we | input | 1 | Flag-clear write strobe |
| clr_mask | input | 4 | Write-one-to-clear bits, aligned with `flags` |
| flags | output | 4 | {aux high, aux low, temp high, temp low} |
| alert_n | output | 1 | Active-low alert, or general-purpose output |

## Verification
The hardest case to reach from the ports is a set and a clear that hit the same flag in the same cycle. It needs a violating result with an enabled channel, and a clear write on exactly that bit, presented in one cycle. The directed stimulus builds this case on purpose. A long random phase then mixes bound-hugging values, tags, clears and control words, which revisits the collision many times under every mask and mode combination. Values equal to the bounds are also driven on purpose, so that a comparison that is off by one shows up.

// File: rtl/lim_alert_pkg.sv
// Shared constants for the limit alert unit: channel tags, control-word
// bit positions and flag indices. Assumes a 16-bit control word.
package lim_alert_pkg;
    localparam int TAG_W       = 3;
    localparam logic [TAG_W-1:0] TAG_TEMP = 3'd5;
    localparam logic [TAG_W-1:0] TAG_AUX  = 3'd6;
    localparam int NSRC        = 2;            // monitored sources
    localparam int NFLAG       = 2 * NSRC;     // low+high per source
    localparam int CB_MASK_T   = 15;
    localparam int CB_MASK_A   = 14;
    localparam int CB_MODE     = 13;
    localparam int CB_GPIO     = 12;
    localparam int CB_SEQ_T    = 2;
    localparam int CB_SEQ_A    = 3;
endpackage

// File: rtl/lim_cmp.sv
// Window comparator for one source. Flags a strict under- or over-range
// value while chk_en is high. Assumes unsigned values; equal means in range.
module lim_cmp #(
    parameter int DATA_W = 12
) (
    input  logic              chk_en,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output logic              below,
    output logic              above
);
    // strict comparisons, qualified by enable
    always_comb begin
        below = chk_en && (value < lo);
        above = chk_en && (value > hi);
    end
endmodule

// File: rtl/lim_flag_bank.sv
// Sticky flag register bank with write-one-to-clear. A set in the same
// cycle as a clear wins. Assumes set/clr are single-cycle requests.
module lim_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // hold, clear on request, set with priority
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set;
    end

    // R2
    set_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
    // R6
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr == '0) |=> ((flags & $past(flags)) == $past(flags)));
    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set & clr) != '0) |=> ((flags & $past(set & clr)) != '0));
endmodule

// File: rtl/lim_pin_drive.sv
// Drives the shared pin: an active-low OR of the unmasked flags, or the
// general-purpose data bit when the mode bit selects it.
module lim_pin_drive #(
    parameter int NSRC = 2
) (
    input  logic [2*NSRC-1:0] flags,
    input  logic [NSRC-1:0]   src_mask,
    input  logic              gp_mode,
    input  logic              gp_data,
    output logic              alert_n
);
    logic [NSRC-1:0] src_hit;

    // one hit per source: either of its flags, unless masked
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign src_hit[s] = (flags[2*s] | flags[2*s+1]) & ~src_mask[s];
    end

    // pin select
    always_comb begin
        alert_n = gp_mode ? gp_data : ~(|src_hit);
    end
endmodule

// File: rtl/lim_alert_top.sv
// Limit alert unit top. Routes results to per-source comparators, keeps
// sticky flags and drives the alert/general-purpose pin. Assumes the limits
// and control word are static around a result strobe.
module lim_alert_top
    import lim_alert_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [2:0]        res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] temp_lo,
    input  logic [DATA_W-1:0] temp_hi,
    input  logic [DATA_W-1:0] aux_lo,
    input  logic [DATA_W-1:0] aux_hi,
    input  logic [15:0]       ctrl_word,
    input  logic              clr_we,
    input  logic [3:0]        clr_mask,
    output logic [3:0]        flags,
    output logic              alert_n
);
    logic [DATA_W-1:0] lo_arr [NSRC];
    logic [DATA_W-1:0] hi_arr [NSRC];
    logic [NSRC-1:0]   chk_en;
    logic [NSRC-1:0]   src_mask;
    logic [NFLAG-1:0]  set_req;
    logic [NFLAG-1:0]  clr_req;

    // per-source bounds, enables and masks
    always_comb begin
        lo_arr[0]   = temp_lo;
        hi_arr[0]   = temp_hi;
        lo_arr[1]   = aux_lo;
        hi_arr[1]   = aux_hi;
        chk_en[0]   = res_valid && (res_tag == TAG_TEMP) && ctrl_word[CB_SEQ_T];
        chk_en[1]   = res_valid && (res_tag == TAG_AUX)  && ctrl_word[CB_SEQ_A];
        src_mask[0] = ctrl_word[CB_MASK_T];
        src_mask[1] = ctrl_word[CB_MASK_A];
    end

    // clear request only when the write strobe is present
    always_comb clr_req = clr_we ? clr_mask : '0;

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        lim_cmp #(.DATA_W(DATA_W)) u_cmp (
            .chk_en (chk_en[s]),
            .value  (res_data),
            .lo     (lo_arr[s]),
            .hi     (hi_arr[s]),
            .below  (set_req[2*s]),
            .above  (set_req[2*s+1])
        );
    end

    lim_flag_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_req),
        .clr   (clr_req),
        .flags (flags)
    );

    lim_pin_drive #(.NSRC(NSRC)) u_pin (
        .flags    (flags),
        .src_mask (src_mask),
        .gp_mode  (ctrl_word[CB_MODE]),
        .gp_data  (ctrl_word[CB_GPIO]),
        .alert_n  (alert_n)
    );

    // R4
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !clr_we) |=> $stable(flags));
    // R5
    seq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[CB_SEQ_T] && !ctrl_word[CB_SEQ_A] && !clr_we) |=> $stable(flags));
    // R8
    alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[CB_MODE] && flags == '0) |-> alert_n);
    // R9
    all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[CB_MODE] && ctrl_word[CB_MASK_T] && ctrl_word[CB_MASK_A]) |-> alert_n);
endmodule

// File: tb/lim_alert_top_test.sv
module lim_alert_top_test;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [2:0]    res_tag = '0;
    logic [DW-1:0] res_data = '0;
    logic [DW-1:0] temp_lo = 12'd100, temp_hi = 12'd200;
    logic [DW-1:0] aux_lo = 12'd50, aux_hi = 12'd3000;
    logic [15:0]   ctrl_word = 16'h000C;
    logic          clr_we = 1'b0;
    logic [3:0]    clr_mask = '0;
    logic [3:0]    flags;
    logic          alert_n;

    int checks = 0, fails = 0;
    bit armed = 0;
    string phase = "R1";
    int m_flags = 0;   // reference model state

    always #5 clk = ~clk;

    lim_alert_top #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data), .temp_lo(temp_lo), .temp_hi(temp_hi),
        .aux_lo(aux_lo), .aux_hi(aux_hi), .ctrl_word(ctrl_word),
        .clr_we(clr_we), .clr_mask(clr_mask), .flags(flags), .alert_n(alert_n)
    );

    // behavioural reference: next flags from this edge's inputs
    always @(posedge clk) begin
        int nxt, v;
        if (!rst_n) m_flags = 0;
        else begin
            nxt = m_flags;
            v = int'(res_data);
            if (clr_we) nxt = nxt & ~int'(clr_mask);
            if (res_valid && res_tag == 3'd5 && ctrl_word[2]) begin
                if (v < int'(temp_lo)) nxt = nxt | 1;
                if (v > int'(temp_hi)) nxt = nxt | 2;
            end
            if (res_valid && res_tag == 3'd6 && ctrl_word[3]) begin
                if (v < int'(aux_lo)) nxt = nxt | 4;
                if (v > int'(aux_hi)) nxt = nxt | 8;
            end
            m_flags = nxt;
        end
        armed = 1;
    end

    function automatic bit exp_alert();
        bit t_hit, a_hit;
        if (ctrl_word[13]) return ctrl_word[12];
        t_hit = ((m_flags & 3) != 0) && !ctrl_word[15];
        a_hit = ((m_flags & 12) != 0) && !ctrl_word[14];
        return !(t_hit || a_hit);
    endfunction

    // compare on every falling edge
    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (int'(flags) != m_flags) begin
                fails++;
                $display("FAIL %s flags actual=%h expected=%h", phase, flags, m_flags[3:0]);
            end
            checks++;
            if (alert_n !== exp_alert()) begin
                fails++;
                $display("FAIL %s alert_n actual=%b expected=%b", phase, alert_n, exp_alert());
            end
        end
    end

    task automatic put(input bit v, input logic [2:0] t, input int d,
                       input bit cw, input logic [3:0] cm);
        @(negedge clk); #1;
        res_valid = v; res_tag = t; res_data = d[DW-1:0];
        clr_we = cw; clr_mask = cm;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(0, 3'd0, 0, 0, 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired expected=finish actual=hang");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst_n = 1'b1;
        idle(2);
        // R2: temperature window with equal-bound cases
        phase = "R2";
        put(1, 3'd5, 99, 0, 0);  idle(1);
        put(1, 3'd5, 100, 0, 0); put(1, 3'd5, 200, 0, 0);
        put(1, 3'd5, 201, 0, 0); idle(1);
        // R6: writing zeros keeps flags, writing ones clears
        phase = "R6";
        put(0, 3'd0, 0, 1, 4'h0); put(0, 3'd0, 0, 1, 4'h1); put(0, 3'd0, 0, 1, 4'h2);
        idle(1);
        // R3: auxiliary window
        phase = "R3";
        put(1, 3'd6, 49, 0, 0); put(1, 3'd6, 50, 0, 0);
        put(1, 3'd6, 3000, 0, 0); put(1, 3'd6, 3001, 0, 0); idle(1);
        put(0, 3'd0, 0, 1, 4'hC);
        // R4: no strobe or foreign tag
        phase = "R4";
        put(0, 3'd5, 0, 0, 0); put(1, 3'd1, 0, 0, 0); put(1, 3'd7, 4095, 0, 0);
        idle(1);
        // R5: sequence enables off
        phase = "R5";
        @(negedge clk); #1 ctrl_word = 16'h0008;
        put(1, 3'd5, 0, 0, 0); put(1, 3'd6, 4095, 0, 0); idle(1);
        @(negedge clk); #1 ctrl_word = 16'h0004;
        put(1, 3'd6, 0, 0, 0); put(1, 3'd5, 4095, 0, 0); idle(1);
        put(0, 3'd0, 0, 1, 4'hF);
        // R7: set collides with clear
        phase = "R7";
        @(negedge clk); #1 ctrl_word = 16'h000C;
        put(1, 3'd5, 0, 1, 4'h1); idle(1);
        put(1, 3'd6, 4000, 1, 4'hF); idle(1);
        // R9: masks
        phase = "R9";
        @(negedge clk); #1 ctrl_word = 16'h800C; idle(1);
        @(negedge clk); #1 ctrl_word = 16'hC00C; idle(1);
        put(0, 3'd0, 0, 1, 4'hF);
        put(1, 3'd5, 0, 0, 0); idle(1);
        @(negedge clk); #1 ctrl_word = 16'h400C; idle(1);
        put(0, 3'd0, 0, 1, 4'hF);
        // R8: alert follows flags combinationally
        phase = "R8";
        put(1, 3'd6, 0, 0, 0); idle(1); put(0, 3'd0, 0, 1, 4'h4); idle(1);
        // R10: general-purpose mode
        phase = "R10";
        @(negedge clk); #1 ctrl_word = 16'h200C; idle(1);
        @(negedge clk); #1 ctrl_word = 16'h300C; idle(1);
        put(1, 3'd5, 300, 0, 0); idle(1);
        @(negedge clk); #1 ctrl_word = 16'h200C; idle(1);
        put(0, 3'd0, 0, 1, 4'hF);
        // random mix around the bounds
        phase = "R3";
        for (int i = 0; i < 600; i++) begin
            int sel, d;
            sel = $urandom_range(0, 5);
            case (sel)
                0: d = 99 + $urandom_range(0, 2);
                1: d = 199 + $urandom_range(0, 2);
                2: d = 49 + $urandom_range(0, 2);
                3: d = 2999 + $urandom_range(0, 2);
                default: d = $urandom_range(0, 4095);
            endcase
            if (i % 37 == 0) begin
                @(negedge clk); #1 ctrl_word = 16'($urandom_range(0, 65535));
            end
            put($urandom_range(0, 3) != 0,
                ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7))
                                            : (($urandom_range(0, 1) != 0) ? 3'd5 : 3'd6),
                d, $urandom_range(0, 2) == 0, 4'($urandom_range(0, 15)));
        end
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule